// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer and the window invalid mask for a processor whose registers are arranged as a ring of overlapping windows. It serves one request per cycle: a SAVE moves to the previous window, a RESTORE or a return-from-trap moves to the next one, and two write requests load the processor status word or the invalid mask. Every move wraps around the window count, and the destination window is checked against the invalid mask before anything changes.

When a move would land on an invalid window, when a return-from-trap arrives with traps already enabled, or when a status write names a window that does not exist, the block leaves all state untouched. It then reports a registered, single-cycle trap indication with a 3-bit code. The status word is available at all times as a combinational read of the live state.

Top module: `window_ptr_ctrl`

## Requirements
- R1: After reset the window pointer is 0, no trap is reported, the invalid mask is all zero and the status word reads VERSION in bits 31:24 with only the supervisor bit (bit 7) set below them.
- R2: A SAVE (req_op 0) with no trap sets the window pointer to its previous value minus one, with 0 wrapping to NW-1.
- R3: A RESTORE (req_op 1) with no trap sets the window pointer to its previous value plus one, with NW-1 wrapping to 0.
- R4: If the invalid-mask bit of the SAVE destination is set, trap code 1 (overflow) is reported and no state changes.
- R5: If the invalid-mask bit of the RESTORE or return-from-trap destination is set, trap code 2 (underflow) is reported and no state changes.
- R6: A return-from-trap (req_op 2) with the enable-trap bit (bit 5) already set reports trap code 3 (illegal) and changes nothing; otherwise it sets enable-trap, copies previous-supervisor (bit 6) into supervisor (bit 7) and moves to the next window.
- R7: A status write (req_op 3) whose window field, wr_data[4:0], is NW or greater reports trap code 3 and changes no state.
- R8: A legal status write loads condition codes from bits 23:20, the FP-enable flag from bit 12, the interrupt level from bits 11:8, supervisor from bit 7, previous-supervisor from bit 6, enable-trap from bit 5 and the window pointer from bits 4:0.
- R9: The status word always reads those fields from live state at those positions, with VERSION in bits 31:24 and every other bit zero.
- R10: A mask write (req_op 4) loads the invalid mask from wr_data[NW-1:0] without a trap; the new mask governs the next move.
- R11: Results appear one clock edge after the request; the trap indication lasts one cycle, and an idle cycle or an unused op code (5 to 7) leaves all state unchanged with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request kind: 0 save, 1 restore, 2 return-from-trap, 3 status write, 4 mask write |
| wr_data | input | 32 | Write payload for status and mask writes |
| cwp | output | $clog2(NW) | Current window pointer |
| wim | output | NW | Window invalid mask |
| trap_valid | output | 1 | One-cycle trap indication |
| trap_code | output | 3 | 1 overflow, 2 underflow, 3 illegal |
| status_rd | output | 32 | Live status word |

## Verification
Every request is applied at a falling edge, and its effect on the pointer, the mask, the trap pair and the status word is due after exactly one rising edge, so the bench samples all of them at the next falling edge. The status word is combinational from state, so it is compared in that same sample. The trap is then expected to be low one cycle later, which the bench checks at the start of every following request.

// File: rtl/wptr_pkg.sv
// Shared encodings for the window pointer controller.
// Assumes: request and trap codes are 3 bits wide.
package wptr_pkg;
    typedef enum logic [2:0] {
        OP_SAVE    = 3'd0,
        OP_RESTORE = 3'd1,
        OP_RETT    = 3'd2,
        OP_WR_SW   = 3'd3,
        OP_WR_WIM  = 3'd4
    } wop_e;

    typedef enum logic [2:0] {
        TC_NONE  = 3'd0,
        TC_OVER  = 3'd1,
        TC_UNDER = 3'd2,
        TC_ILL   = 3'd3
    } tcode_e;

    // Status word bit positions
    localparam int SW_ET  = 5;
    localparam int SW_PS  = 6;
    localparam int SW_S   = 7;
    localparam int SW_PIL = 8;
    localparam int SW_EF  = 12;
    localparam int SW_ICC = 20;
    localparam int SW_VER = 24;
endpackage

// File: rtl/wptr_step.sv
// Computes the neighbouring windows of a pointer on a ring of NW windows.
// Assumes: cur is always below NW.
module wptr_step #(
    parameter int NW = 8,
    localparam int CW = (NW > 2) ? $clog2(NW) : 1
) (
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] up,
    output logic [CW-1:0] down
);
    localparam logic [CW-1:0] LAST = CW'(NW - 1);

    // Wrap-around increment and decrement
    always_comb begin
        up   = (cur == LAST) ? '0 : cur + CW'(1);
        down = (cur == '0) ? LAST : cur - CW'(1);
    end
endmodule

// File: rtl/wptr_sw_pack.sv
// Assembles the status word from live state fields.
// Assumes: window pointer fits in 5 bits (NW <= 32).
module wptr_sw_pack
    import wptr_pkg::*;
#(
    parameter int         CW      = 3,
    parameter logic [7:0] VERSION = 8'hA5
) (
    input  logic [CW-1:0] cwp,
    input  logic          et,
    input  logic          ps,
    input  logic          s,
    input  logic [3:0]    pil,
    input  logic          ef,
    input  logic [3:0]    icc,
    output logic [31:0]   word
);
    // Place each field at its bit position, all else zero
    always_comb begin
        word                     = '0;
        word[4:0]                = 5'(cwp);
        word[SW_ET]              = et;
        word[SW_PS]              = ps;
        word[SW_S]               = s;
        word[SW_PIL +: 4]        = pil;
        word[SW_EF]              = ef;
        word[SW_ICC +: 4]        = icc;
        word[SW_VER +: 8]        = VERSION;
    end
endmodule

// File: rtl/window_ptr_ctrl.sv
// Window pointer and invalid-mask controller. One request per cycle;
// moves wrap modulo NW, invalid destinations trap without state change.
// Assumes: 2 <= NW <= 32, synchronous active-low reset.
module window_ptr_ctrl
    import wptr_pkg::*;
#(
    parameter int         NW      = 8,
    parameter logic [7:0] VERSION = 8'hA5,
    localparam int        CW      = (NW > 2) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [31:0]   wr_data,
    output logic [CW-1:0] cwp,
    output logic [NW-1:0] wim,
    output logic          trap_valid,
    output logic [2:0]    trap_code,
    output logic [31:0]   status_rd
);
    logic [CW-1:0] cwp_q, cwp_d, w_up, w_dn;
    logic [NW-1:0] wim_q, wim_d;
    logic          et_q, et_d, s_q, s_d, ps_q, ps_d, ef_q, ef_d;
    logic [3:0]    pil_q, pil_d, icc_q, icc_d;
    logic          trap_d;
    tcode_e        code_d;
    logic [2:0]    code_q;
    logic          trap_q;

    wptr_step #(.NW(NW)) u_step (.cur(cwp_q), .up(w_up), .down(w_dn));

    wptr_sw_pack #(.CW(CW), .VERSION(VERSION)) u_pack (
        .cwp(cwp_q), .et(et_q), .ps(ps_q), .s(s_q), .pil(pil_q),
        .ef(ef_q), .icc(icc_q), .word(status_rd)
    );

    // Decide next state and trap for the current request
    always_comb begin
        cwp_d = cwp_q; wim_d = wim_q; et_d = et_q; s_d = s_q; ps_d = ps_q;
        ef_d = ef_q; pil_d = pil_q; icc_d = icc_q;
        trap_d = 1'b0; code_d = TC_NONE;
        if (req_valid) begin
            case (req_op)
                OP_SAVE: begin
                    if (wim_q[w_dn]) begin
                        trap_d = 1'b1; code_d = TC_OVER;
                    end else begin
                        cwp_d = w_dn;
                    end
                end
                OP_RESTORE: begin
                    if (wim_q[w_up]) begin
                        trap_d = 1'b1; code_d = TC_UNDER;
                    end else begin
                        cwp_d = w_up;
                    end
                end
                OP_RETT: begin
                    if (et_q) begin
                        trap_d = 1'b1; code_d = TC_ILL;
                    end else if (wim_q[w_up]) begin
                        trap_d = 1'b1; code_d = TC_UNDER;
                    end else begin
                        cwp_d = w_up; et_d = 1'b1; s_d = ps_q;
                    end
                end
                OP_WR_SW: begin
                    if (int'(wr_data[4:0]) >= NW) begin
                        trap_d = 1'b1; code_d = TC_ILL;
                    end else begin
                        cwp_d = CW'(wr_data[4:0]);
                        et_d  = wr_data[SW_ET];
                        ps_d  = wr_data[SW_PS];
                        s_d   = wr_data[SW_S];
                        pil_d = wr_data[SW_PIL +: 4];
                        ef_d  = wr_data[SW_EF];
                        icc_d = wr_data[SW_ICC +: 4];
                    end
                end
                OP_WR_WIM: wim_d = wr_data[NW-1:0];
                default: ;
            endcase
        end
    end

    // Register state and the one-cycle trap pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q <= '0; wim_q <= '0; et_q <= 1'b0; s_q <= 1'b1; ps_q <= 1'b0;
            ef_q <= 1'b0; pil_q <= '0; icc_q <= '0;
            trap_q <= 1'b0; code_q <= TC_NONE;
        end else begin
            cwp_q <= cwp_d; wim_q <= wim_d; et_q <= et_d; s_q <= s_d; ps_q <= ps_d;
            ef_q <= ef_d; pil_q <= pil_d; icc_q <= icc_d;
            trap_q <= trap_d; code_q <= code_d;
        end
    end

    assign cwp        = cwp_q;
    assign wim        = wim_q;
    assign trap_valid = trap_q;
    assign trap_code  = code_q;
endmodule

// File: rtl/wptr_chk.sv
// Property checker for window_ptr_ctrl, attached by bind.
// Assumes: observes only the top-level ports.
module wptr_chk
    import wptr_pkg::*;
#(
    parameter int NW = 8,
    localparam int CW = (NW > 2) ? $clog2(NW) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic [CW-1:0] cwp,
    input logic          trap_valid,
    input logic [2:0]    trap_code,
    input logic [31:0]   status_rd
);
    localparam logic [CW-1:0] LAST = CW'(NW - 1);

    // R2
    save_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0) |=> (trap_valid ||
            cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - CW'(1))));

    // R3
    restore_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1) |=> (trap_valid ||
            cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + CW'(1))));

    // R6
    rett_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2 && status_rd[SW_ET]) |=>
            (trap_valid && trap_code == 3'd3));

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!trap_valid && $stable(cwp) && $stable(status_rd)));

    // R4
    trap_keeps_cwp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op <= 3'd3) |=> (!trap_valid || $stable(cwp)));

    // R11
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_code >= 3'd1 && trap_code <= 3'd3));

    // R9
    cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cwp) < NW) && status_rd[4:0] == 5'(cwp));
endmodule

bind window_ptr_ctrl wptr_chk #(.NW(NW)) u_wptr_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .cwp(cwp), .trap_valid(trap_valid), .trap_code(trap_code),
    .status_rd(status_rd)
);

// File: tb/tb_window_ptr_ctrl.sv
module tb_window_ptr_ctrl;
    localparam int NW = 8;
    localparam int CW = $clog2(NW);
    localparam logic [7:0] VER = 8'hA5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [31:0]   wr_data = '0;
    logic [CW-1:0] cwp;
    logic [NW-1:0] wim;
    logic          trap_valid;
    logic [2:0]    trap_code;
    logic [31:0]   status_rd;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench model state
    int         m_cwp;
    logic [NW-1:0] m_wim;
    logic       m_et, m_s, m_ps, m_ef;
    logic [3:0] m_pil, m_icc;

    always #2 clk = ~clk;

    window_ptr_ctrl #(.NW(NW), .VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .wr_data(wr_data), .cwp(cwp), .wim(wim), .trap_valid(trap_valid),
        .trap_code(trap_code), .status_rd(status_rd)
    );

    function automatic logic [31:0] exp_sw();
        logic [31:0] w = '0;
        w[4:0] = 5'(m_cwp); w[5] = m_et; w[6] = m_ps; w[7] = m_s;
        w[11:8] = m_pil; w[12] = m_ef; w[23:20] = m_icc; w[31:24] = VER;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] op, input logic [31:0] d, input string req);
        int up, dn;
        logic et_trap = 1'b0;
        logic [2:0] ecode = 3'd0;
        @(negedge clk);
        chk(trap_valid == 1'b0, "R11 pulse", 32'(trap_valid), 0);
        req_valid = 1'b1; req_op = op; wr_data = d;
        up = (m_cwp == NW - 1) ? 0 : m_cwp + 1;
        dn = (m_cwp == 0) ? NW - 1 : m_cwp - 1;
        case (op)
            3'd0: if (m_wim[dn]) ecode = 3'd1; else m_cwp = dn;
            3'd1: if (m_wim[up]) ecode = 3'd2; else m_cwp = up;
            3'd2: if (m_et) ecode = 3'd3;
                  else if (m_wim[up]) ecode = 3'd2;
                  else begin m_cwp = up; m_et = 1'b1; m_s = m_ps; end
            3'd3: if (int'(d[4:0]) >= NW) ecode = 3'd3;
                  else begin
                      m_cwp = int'(d[4:0]); m_et = d[5]; m_ps = d[6]; m_s = d[7];
                      m_pil = d[11:8]; m_ef = d[12]; m_icc = d[23:20];
                  end
            3'd4: m_wim = d[NW-1:0];
            default: ;
        endcase
        et_trap = (ecode != 3'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(int'(cwp) == m_cwp, req, 32'(cwp), 32'(m_cwp));
        chk(trap_valid == et_trap, req, 32'(trap_valid), 32'(et_trap));
        if (et_trap) chk(trap_code == ecode, req, 32'(trap_code), 32'(ecode));
        chk(status_rd == exp_sw(), {req, " R9"}, status_rd, exp_sw());
        chk(wim == m_wim, {req, " R10"}, 32'(wim), 32'(m_wim));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        m_cwp = 0; m_wim = '0; m_et = 0; m_s = 1; m_ps = 0; m_ef = 0; m_pil = 0; m_icc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        chk(cwp == '0, "R1 cwp", 32'(cwp), 0);
        chk(!trap_valid, "R1 trap", 32'(trap_valid), 0);
        chk(wim == '0, "R1 wim", 32'(wim), 0);
        chk(status_rd == {VER, 24'h000080}, "R1 status", status_rd, {VER, 24'h000080});
        // R2 save wraps 0 -> NW-1, then steps down
        do_req(3'd0, 0, "R2 save wrap");
        do_req(3'd0, 0, "R2 save");
        // R3 restore wraps NW-1 -> 0
        do_req(3'd1, 0, "R3 restore");
        do_req(3'd1, 0, "R3 restore wrap");
        // R10 mask write, R4 overflow on save into window NW-1
        do_req(3'd4, 32'(1 << (NW - 1)), "R10 mask write");
        do_req(3'd0, 0, "R4 overflow");
        // R5 underflow: mask window 1
        do_req(3'd4, 32'h2, "R10 mask write");
        do_req(3'd1, 0, "R5 underflow restore");
        do_req(3'd2, 0, "R5 underflow rett");
        // R6 rett legal: PS=1, S=0, ET=0 at window NW-1
        do_req(3'd4, 0, "R10 clear mask");
        do_req(3'd3, 32'h0000_0040 | 32'(NW - 1), "R8 status write");
        do_req(3'd2, 0, "R6 rett ok");
        do_req(3'd2, 0, "R6 rett illegal");
        // R7 illegal window field at boundary NW and above
        do_req(3'd3, 32'(NW), "R7 field NW");
        do_req(3'd3, 32'h00F0_1F1F, "R7 field 31");
        // R8 all fields, legal boundary NW-1
        do_req(3'd3, 32'h00A0_1AE0 | 32'(NW - 1), "R8 status write full");
        // R11 unused op codes
        do_req(3'd5, 32'hFFFF_FFFF, "R11 op5");
        do_req(3'd7, 32'hFFFF_FFFF, "R11 op7");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int sel = int'($urandom_range(0, 9));
            logic [2:0] op;
            logic [31:0] d = $urandom;
            if (sel < 3) op = 3'd0;
            else if (sel < 6) op = 3'd1;
            else if (sel < 7) op = 3'd2;
            else if (sel < 8) op = 3'd3;
            else if (sel < 9) begin op = 3'd4; d = $urandom & $urandom & $urandom; end
            else op = 3'(5 + $urandom_range(0, 2));
            do_req(op, d, "R2 R3 R4 R5 R6 R7 R8 random");
        end
        @(negedge clk);
        chk(!trap_valid, "R11 final", 32'(trap_valid), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule